// File: doc/BRIEF.md
# Paged Memory Window Decoder

This block sits on the bus of an 8-bit host processor and opens a 256-byte window, at host addresses `FD00`–`FDFF`, onto a 24-bit device address space. Three fixed host addresses act as control registers. `FCFF` holds the number of the device that is currently selected. `FCFD` holds the high byte of the page and `FCFE` holds the low byte. A host access that falls inside the window is passed to the device-side bus with the address `{page_hi, page_lo, host_addr[7:0]}`. This happens only while the selected number matches this device's own number, which is a parameter, so several such devices can share the same control addresses.

A host bus cycle is the span during which `host_cyc` is high. It may last one clock or many. The block issues exactly one device strobe for each cycle, one clock after the cycle starts. Alongside the strobe it reports whether the target is on-board memory or the sound register page. Memory size is a parameter. The register page is `FEFE` or `FEFC`, depending on the byte-order parameter.

The host read data port has no tri-state. "Not driving" is shown by `host_rdata_en` being low, and `host_rdata` is then 00.

Top module: `paged_window_dec`

## Requirements
- R1: After reset the select register holds 00, no strobe is issued, and `host_rdata_en` stays low for window accesses.
- R2: A write to `FCFF` stores the device number. Only a value equal to `DEV_ID` (default D0) selects this block. While it is unselected, window accesses produce no strobe and no read drive.
- R3: While the block is selected, writes to `FCFD` and `FCFE` set the high and low page bytes. Reads of those addresses return the last value written.
- R4: A window access presents the device address `{page_hi, page_lo, host_addr[7:0]}`. Bits 23:16 are page_hi, bits 15:8 are page_lo and bits 7:0 are the host low byte.
- R5: Each selected window access raises `dev_stb` for exactly one clock, the clock after the first clock of the host cycle, whatever the length of the cycle. `dev_we` is the inverse of `host_rnw`, and `dev_wdata` carries the host write byte.
- R6: `dev_reg_sel` is 1 when the page equals FEFE with `BIG_ENDIAN`=0, or FEFC with `BIG_ENDIAN`=1.
- R7: `dev_mem_sel` is 1 when the page is below `MEM_BYTES`/256, so 0800 with the default of 512 KB. A read of a page that has neither target returns FF.
- R8: A selected window read drives `host_rdata_en` high and returns `dev_rdata`. The drive is present only while `host_cyc` and `host_rnw` are both high.
- R9: A read of `FCFF` returns `DEV_ID` when the block is selected. It is not driven when the block is unselected.
- R10: Writes to `FCFD` and `FCFE` while the block is unselected leave the page unchanged.
- R11: Host addresses outside the window and the three control addresses produce no strobe and no read drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cyc | input | 1 | High for the duration of a host bus cycle |
| host_rnw | input | 1 | 1 = read, 0 = write |
| host_addr | input | 16 | Host address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data to the host |
| host_rdata_en | output | 1 | Block drives the host data bus |
| dev_stb | output | 1 | One-clock device access strobe |
| dev_we | output | 1 | Device access is a write |
| dev_addr | output | 24 | Device address, held between accesses |
| dev_wdata | output | 8 | Device write data |
| dev_mem_sel | output | 1 | Access targets on-board memory |
| dev_reg_sel | output | 1 | Access targets the sound register page |
| dev_rdata | input | 8 | Read data from the device side |

## Verification
The bench stretches host cycles to six clocks, and a design that strobed on the level of `host_cyc` instead of its start would issue several device accesses. It writes page registers while a foreign device number is selected and then reads them back after reselecting. A decoder that ignored the select condition would corrupt the page. Pages 07FF, 0800, FEFE and FEFC are probed, which catches an off-by-one in the memory limit and a swapped register page. Reads of unbacked pages must return FF rather than device data.

// File: rtl/pwd_pkg.sv
package pwd_pkg;

    localparam logic [15:0] SEL_ADDR     = 16'hFCFF;
    localparam logic [15:0] PAGE_HI_ADDR = 16'hFCFD;
    localparam logic [15:0] PAGE_LO_ADDR = 16'hFCFE;
    localparam logic [7:0]  WIN_HI       = 8'hFD;
    localparam logic [7:0]  UNBACKED_RD  = 8'hFF;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_MEM  = 2'd1,
        TGT_REG  = 2'd2
    } tgt_e;

    typedef enum logic [1:0] {
        CTL_NONE = 2'd0,
        CTL_SEL  = 2'd1,
        CTL_PHI  = 2'd2,
        CTL_PLO  = 2'd3
    } ctl_e;

    typedef struct packed {
        logic        we;
        logic [23:0] addr;
        logic [7:0]  wdata;
        tgt_e        tgt;
    } dev_req_t;

    function automatic ctl_e ctl_decode(input logic [15:0] a);
        ctl_e r;
        case (a)
            SEL_ADDR:     r = CTL_SEL;
            PAGE_HI_ADDR: r = CTL_PHI;
            PAGE_LO_ADDR: r = CTL_PLO;
            default:      r = CTL_NONE;
        endcase
        return r;
    endfunction

    function automatic logic in_window(input logic [15:0] a);
        return a[15:8] == WIN_HI;
    endfunction

endpackage

// File: rtl/pwd_cycle_ctrl.sv
module pwd_cycle_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic host_cyc,
    output logic start
);
    logic cyc_q;

    always_ff @(posedge clk) begin
        if (rst) cyc_q <= 1'b0;
        else     cyc_q <= host_cyc;
    end

    assign start = host_cyc && !cyc_q;
endmodule

// File: rtl/pwd_ctrl_regs.sv
module pwd_ctrl_regs
    import pwd_pkg::*;
#(
    parameter logic [7:0] DEV_ID = 8'hD0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [15:0] addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  sel_q,
    output logic [15:0] page_q,
    output logic        selected
);
    ctl_e ctl;
    assign ctl      = ctl_decode(addr);
    assign selected = (sel_q == DEV_ID);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= 8'h00;
            page_q <= 16'h0000;
        end else if (wr_en) begin
            case (ctl)
                CTL_SEL: sel_q <= wdata;
                CTL_PHI: if (selected) page_q[15:8] <= wdata;
                CTL_PLO: if (selected) page_q[7:0]  <= wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pwd_target_dec.sv
module pwd_target_dec
    import pwd_pkg::*;
#(
    parameter bit          BIG_ENDIAN = 1'b0,
    parameter int unsigned MEM_BYTES  = 524288
) (
    input  logic [15:0] page,
    output tgt_e        tgt
);
    localparam int unsigned MEM_PAGES = MEM_BYTES / 256;
    localparam logic [16:0] MEM_LIMIT = 17'(MEM_PAGES);

    logic [15:0] reg_page;

    generate
        if (BIG_ENDIAN) begin : g_be
            assign reg_page = 16'hFEFC;
        end else begin : g_le
            assign reg_page = 16'hFEFE;
        end
    endgenerate

    always_comb begin
        if (page == reg_page)                tgt = TGT_REG;
        else if ({1'b0, page} < MEM_LIMIT)   tgt = TGT_MEM;
        else                                 tgt = TGT_NONE;
    end
endmodule

// File: rtl/pwd_dev_port.sv
module pwd_dev_port
    import pwd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     fire,
    input  dev_req_t req_in,
    output logic     stb,
    output dev_req_t req_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stb   <= 1'b0;
            req_q <= '{we: 1'b0, addr: 24'h0, wdata: 8'h0, tgt: TGT_NONE};
        end else begin
            stb <= fire;
            if (fire) req_q <= req_in;
        end
    end
endmodule

// File: rtl/paged_window_dec.sv
module paged_window_dec
    import pwd_pkg::*;
#(
    parameter logic [7:0]  DEV_ID     = 8'hD0,
    parameter bit          BIG_ENDIAN = 1'b0,
    parameter int unsigned MEM_BYTES  = 524288
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_cyc,
    input  logic        host_rnw,
    input  logic [15:0] host_addr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    output logic        host_rdata_en,
    output logic        dev_stb,
    output logic        dev_we,
    output logic [23:0] dev_addr,
    output logic [7:0]  dev_wdata,
    output logic        dev_mem_sel,
    output logic        dev_reg_sel,
    input  logic [7:0]  dev_rdata
);
    logic        start;
    logic [7:0]  sel_q;
    logic [15:0] page_q;
    logic        selected;
    tgt_e        tgt;
    ctl_e        ctl;
    logic        win_hit;
    dev_req_t    req_now;
    dev_req_t    req_q;

    pwd_cycle_ctrl u_cyc (
        .clk      (clk),
        .rst      (rst),
        .host_cyc (host_cyc),
        .start    (start)
    );

    pwd_ctrl_regs #(.DEV_ID(DEV_ID)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (start && !host_rnw),
        .addr     (host_addr),
        .wdata    (host_wdata),
        .sel_q    (sel_q),
        .page_q   (page_q),
        .selected (selected)
    );

    pwd_target_dec #(.BIG_ENDIAN(BIG_ENDIAN), .MEM_BYTES(MEM_BYTES)) u_tgt (
        .page (page_q),
        .tgt  (tgt)
    );

    assign ctl     = ctl_decode(host_addr);
    assign win_hit = in_window(host_addr) && selected;

    assign req_now = '{we:    !host_rnw,
                       addr:  {page_q, host_addr[7:0]},
                       wdata: host_wdata,
                       tgt:   tgt};

    pwd_dev_port u_port (
        .clk    (clk),
        .rst    (rst),
        .fire   (start && win_hit),
        .req_in (req_now),
        .stb    (dev_stb),
        .req_q  (req_q)
    );

    assign dev_we      = req_q.we;
    assign dev_addr    = req_q.addr;
    assign dev_wdata   = req_q.wdata;
    assign dev_mem_sel = (req_q.tgt == TGT_MEM);
    assign dev_reg_sel = (req_q.tgt == TGT_REG);

    // Read path: window data, control readback, or nothing driven.
    always_comb begin
        host_rdata    = 8'h00;
        host_rdata_en = 1'b0;
        if (host_cyc && host_rnw && selected) begin
            if (in_window(host_addr)) begin
                host_rdata_en = 1'b1;
                host_rdata    = (tgt == TGT_NONE) ? UNBACKED_RD : dev_rdata;
            end else begin
                case (ctl)
                    CTL_SEL: begin host_rdata_en = 1'b1; host_rdata = sel_q;        end
                    CTL_PHI: begin host_rdata_en = 1'b1; host_rdata = page_q[15:8]; end
                    CTL_PLO: begin host_rdata_en = 1'b1; host_rdata = page_q[7:0];  end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/pwd_checker.sv
module pwd_checker (
    input logic        clk,
    input logic        rst,
    input logic        host_cyc,
    input logic        host_rnw,
    input logic [15:0] host_addr,
    input logic        host_rdata_en,
    input logic        dev_stb,
    input logic [23:0] dev_addr,
    input logic        dev_mem_sel,
    input logic        dev_reg_sel
);
    // R5: strobe never lasts two clocks
    p_stb_single_r5: assert property (@(posedge clk) disable iff (rst)
        dev_stb |=> !dev_stb);

    // R11: strobe only follows a host cycle in the window
    p_stb_window_r11: assert property (@(posedge clk) disable iff (rst)
        dev_stb |-> ($past(host_cyc) && $past(host_addr[15:8]) == 8'hFD));

    // R4: low address byte comes from the host
    p_low_byte_r4: assert property (@(posedge clk) disable iff (rst)
        dev_stb |-> dev_addr[7:0] == $past(host_addr[7:0]));

    // R4: device address held between strobes
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !dev_stb |-> $stable(dev_addr));

    // R6, R7: targets exclusive
    p_tgt_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(dev_mem_sel && dev_reg_sel));

    // R8: drive only during a host read cycle
    p_drive_read_r8: assert property (@(posedge clk) disable iff (rst)
        host_rdata_en |-> (host_cyc && host_rnw));
endmodule

bind paged_window_dec pwd_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .host_cyc      (host_cyc),
    .host_rnw      (host_rnw),
    .host_addr     (host_addr),
    .host_rdata_en (host_rdata_en),
    .dev_stb       (dev_stb),
    .dev_addr      (dev_addr),
    .dev_mem_sel   (dev_mem_sel),
    .dev_reg_sel   (dev_reg_sel)
);

// File: tb/paged_window_dec_tb.sv
module paged_window_dec_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        host_cyc = 1'b0;
    logic        host_rnw = 1'b1;
    logic [15:0] host_addr = 16'h0;
    logic [7:0]  host_wdata = 8'h0;
    logic [7:0]  host_rdata;
    logic        host_rdata_en;
    logic        dev_stb;
    logic        dev_we;
    logic [23:0] dev_addr;
    logic [7:0]  dev_wdata;
    logic        dev_mem_sel;
    logic        dev_reg_sel;
    logic [7:0]  dev_rdata;

    int checks = 0;
    int errors = 0;

    int          stb_cnt, stb_first;
    logic [23:0] cap_addr;
    logic        cap_we, cap_mem, cap_reg;
    logic [7:0]  cap_wd, rd;
    logic        rd_en, idle_en;

    always #4 clk = ~clk;

    assign dev_rdata = dev_addr[7:0] ^ 8'h3C;

    paged_window_dec u_dut (
        .clk(clk), .rst(rst), .host_cyc(host_cyc), .host_rnw(host_rnw),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rdata_en(host_rdata_en), .dev_stb(dev_stb), .dev_we(dev_we),
        .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_mem_sel(dev_mem_sel),
        .dev_reg_sel(dev_reg_sel), .dev_rdata(dev_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus(input logic [15:0] a, input logic rnw, input logic [7:0] wd, input int n);
        @(negedge clk);
        host_cyc = 1'b1; host_addr = a; host_rnw = rnw; host_wdata = wd;
        stb_cnt = 0; stb_first = -1;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            if (dev_stb) begin
                stb_cnt++;
                if (stb_first < 0) stb_first = i;
                cap_addr = dev_addr; cap_we = dev_we; cap_wd = dev_wdata;
                cap_mem = dev_mem_sel; cap_reg = dev_reg_sel;
            end
            rd = host_rdata; rd_en = host_rdata_en;
        end
        @(negedge clk);
        host_cyc = 1'b0; host_rnw = 1'b1;
        #1 idle_en = host_rdata_en;
        @(posedge clk); #1;
        if (dev_stb) stb_cnt++;
    endtask

    task automatic set_page(input logic [15:0] p);
        bus(16'hFCFD, 1'b0, p[15:8], 2);
        bus(16'hFCFE, 1'b0, p[7:0], 2);
    endtask

    task automatic t_reset;
        bus(16'hFD10, 1'b1, 8'h0, 2);
        chk("R1 no strobe after reset", stb_cnt, 0);
        chk("R1 no drive after reset", rd_en, 0);
    endtask

    task automatic t_select;
        bus(16'hFCFF, 1'b0, 8'hD1, 2);
        bus(16'hFD00, 1'b1, 8'h0, 2);
        chk("R2 foreign id strobe", stb_cnt, 0);
        chk("R2 foreign id drive", rd_en, 0);
        bus(16'hFCFF, 1'b1, 8'h0, 2);
        chk("R9 FCFF unselected drive", rd_en, 0);
        bus(16'hFCFF, 1'b0, 8'hD0, 2);
        bus(16'hFCFF, 1'b1, 8'h0, 2);
        chk("R9 FCFF readback en", rd_en, 1);
        chk("R9 FCFF readback", rd, 8'hD0);
    endtask

    task automatic t_page;
        set_page(16'h0123);
        bus(16'hFCFD, 1'b1, 8'h0, 2);
        chk("R3 page hi readback", rd, 8'h01);
        bus(16'hFCFE, 1'b1, 8'h0, 2);
        chk("R3 page lo readback", rd, 8'h23);
    endtask

    task automatic t_write;
        bus(16'hFD7E, 1'b0, 8'h5C, 3);
        chk("R5 one strobe", stb_cnt, 1);
        chk("R5 strobe timing", stb_first, 0);
        chk("R4 device address", cap_addr, 24'h01237E);
        chk("R5 write flag", cap_we, 1);
        chk("R5 write data", cap_wd, 8'h5C);
        chk("R7 mem sel", cap_mem, 1);
    endtask

    task automatic t_read;
        bus(16'hFD42, 1'b0 ^ 1'b1, 8'h0, 2);
        chk("R8 read drive", rd_en, 1);
        chk("R8 read data", rd, 8'h42 ^ 8'h3C);
        chk("R5 read flag", cap_we, 0);
        chk("R8 drive released", idle_en, 0);
        bus(16'hFD01, 1'b1, 8'h0, 6);
        chk("R5 long cycle one strobe", stb_cnt, 1);
    endtask

    task automatic t_targets;
        set_page(16'hFEFE);
        bus(16'hFD85, 1'b0, 8'h11, 2);
        chk("R6 reg page sel", cap_reg, 1);
        chk("R6 reg page not mem", cap_mem, 0);
        chk("R4 reg page address", cap_addr, 24'hFEFE85);
        set_page(16'hFEFC);
        bus(16'hFD85, 1'b1, 8'h0, 2);
        chk("R6 other layout page not reg", cap_reg, 0);
        chk("R7 unbacked read", rd, 8'hFF);
        set_page(16'h07FF);
        bus(16'hFD00, 1'b1, 8'h0, 2);
        chk("R7 last mem page", cap_mem, 1);
        set_page(16'h0800);
        bus(16'hFD00, 1'b1, 8'h0, 2);
        chk("R7 first page past mem", cap_mem, 0);
        chk("R7 past mem read", rd, 8'hFF);
    endtask

    task automatic t_deselect;
        set_page(16'h0456);
        bus(16'hFCFF, 1'b0, 8'hD1, 2);
        set_page(16'h5566);
        bus(16'hFCFF, 1'b0, 8'hD0, 2);
        bus(16'hFCFD, 1'b1, 8'h0, 2);
        chk("R10 page hi kept", rd, 8'h04);
        bus(16'hFCFE, 1'b1, 8'h0, 2);
        chk("R10 page lo kept", rd, 8'h56);
    endtask

    task automatic t_outside;
        bus(16'hFC00, 1'b1, 8'h0, 2);
        chk("R11 FC00 strobe", stb_cnt, 0);
        chk("R11 FC00 drive", rd_en, 0);
        bus(16'hFE10, 1'b0, 8'h77, 2);
        chk("R11 FE10 strobe", stb_cnt, 0);
        bus(16'hFCFD, 1'b0, 8'h04, 2);
        chk("R11 control write strobe", stb_cnt, 0);
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset strobe", dev_stb, 0);
        chk("R1 reset drive", host_rdata_en, 0);
        @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_select;
        t_page;
        t_write;
        t_read;
        t_targets;
        t_deselect;
        t_outside;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule